// File: doc/BRIEF.md
# Register-Controlled SPI Master Channel

This block is a single-channel SPI master driven through a small word-wide register port. Software writes a configuration word, enables the channel and writes data words; the shift engine clocks each word out on the serial clock and captures the word coming back. Status flags tell software when the transmit holding register is free, when a received word is waiting and when the line has gone quiet.

The serial clock comes from a power-of-two divider. Clock polarity, clock phase, word length (4 to 32 bits), data-pin direction and chip-select polarity are all programmable. Three transfer modes are offered: full duplex, transmit only, and a receive-only mode that keeps shifting words in until the channel is disabled. Chip-select is never toggled by the engine itself: a software-held force bit asserts it, so one selection can span any number of words. A soft-reset command returns every register to its default and reports its completion in a done flag.

Register offsets on `reg_addr`: 0 configuration, 1 status, 2 enable, 3 transmit data, 4 receive data, 5 soft-reset command, 6 reset-done status. Reads are combinational.

Top module: `spi_chan_master`

## Requirements
- R1: After reset the status register reads 0x6 (bit 1 transmit-empty, bit 2 end-of-transfer, bit 0 receive-available clear), the configuration reads 0, the reset-done register reads 1 and `cs_out` is 0.
- R2: Data leaves most significant bit first. Configuration bit 1 is clock polarity and sets the idle level of `sclk`; bit 0 is clock phase. With phase 0 the input is captured on the first `sclk` edge of each bit, with phase 1 on the second, and the output only changes at the other edge.
- R3: Configuration bits 11:7 hold the word length minus one (codes below 3 give 4 bits). Exactly that many bits are shifted, and the received word is right-justified in the receive register with the upper bits zero.
- R4: Configuration bits 5:2 hold a divider code k; one `sclk` period lasts 2^(k+1) cycles of `clk`. Codes above 12 act as 12.
- R5: In full-duplex mode (bits 13:12 = 00), with the channel enabled (enable register bit 0), a write to the transmit register starts a word; at its end status bit 0 is set, and a read of the receive register clears it.
- R6: In transmit-only mode (bits 13:12 = 10) words start the same way but status bit 0 is never set.
- R7: In receive-only mode (bits 13:12 = 01) one transmit-register write while enabled starts back-to-back words that continue until the enable bit is cleared; the word in progress then finishes and `sclk` stays idle.
- R8: Status bit 1 is set when the transmit register holds no pending word; status bit 2 is set only when no word is pending and none is shifting, so it reads 0 while a word is in flight.
- R9: Configuration bit 20 forces chip-select active; bit 6 set makes the active level low. With bit 20 clear `cs_out` sits at the inactive level.
- R10: Configuration bit 16 set stops D0 from driving, bit 17 set stops D1 from driving, and bit 18 selects the sampled input (0 = D0, 1 = D1).
- R11: A configuration write made while a word is shifting is dropped.
- R12: Writing 1 to bit 0 of the soft-reset register restores all registers to their defaults; the reset-done register reads 0 for a few cycles and then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| sclk | output | 1 | Serial clock |
| cs_out | output | 1 | Chip-select |
| d0_o | output | 1 | Data pin 0 output value |
| d0_oe | output | 1 | Data pin 0 output enable |
| d0_i | input | 1 | Data pin 0 input |
| d1_o | output | 1 | Data pin 1 output value |
| d1_oe | output | 1 | Data pin 1 output enable |
| d1_i | input | 1 | Data pin 1 input |

## Verification
Full-duplex words are sent in all four clock modes with lengths of 4, 8, 12, 16 and 32 bits and asymmetric data, so a swapped bit order, a wrong capture edge or a truncated word shows up as a mismatch on either the serial output or the receive register. Divider codes 0, 3 and an out-of-range 15 separate a linear divider from a power-of-two one and show the clamp. Transmit-only, receive-only with several queued slave words, swapped data pins, every chip-select combination, a configuration write during a word and a soft reset each expose a different mode-dependent path.

// File: rtl/spi_chan_pkg.sv
`timescale 1ns/1ps
package spi_chan_pkg;

  // configuration field positions (decoded by the engine)
  localparam int CFG_CPHA   = 0;
  localparam int CFG_CPOL   = 1;
  localparam int CFG_DIV_LO = 2;
  localparam int CFG_EPOL   = 6;
  localparam int CFG_WL_LO  = 7;
  localparam int CFG_MD_LO  = 12;
  localparam int CFG_NO_D0  = 16;
  localparam int CFG_NO_D1  = 17;
  localparam int CFG_IN_SEL = 18;
  localparam int CFG_FORCE  = 20;

  typedef enum logic [2:0] {
    A_CFG = 3'd0, A_STAT = 3'd1, A_EN = 3'd2, A_TXD = 3'd3,
    A_RXD = 3'd4, A_SYSCTL = 3'd5, A_SYSSTAT = 3'd6, A_NONE = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    M_DUPLEX = 2'b00, M_RXONLY = 2'b01, M_TXONLY = 2'b10, M_RSVD = 2'b11
  } xfer_mode_e;

  // divider code limited to the supported range
  function automatic logic [3:0] clamp_div(input logic [3:0] code, input int unsigned lim);
    return (32'(code) > lim) ? 4'(lim) : code;
  endfunction

  // word length from the stored length-minus-one field
  function automatic logic [5:0] word_bits(input logic [4:0] wl_m1);
    logic [5:0] n;
    n = {1'b0, wl_m1} + 6'd1;
    return (n < 6'd4) ? 6'd4 : n;
  endfunction

endpackage

// File: rtl/spi_chan_clkdiv.sv
`timescale 1ns/1ps
module spi_chan_clkdiv
  import spi_chan_pkg::*;
#(
  parameter int DIV_MAX = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick
);
  localparam int CNT_W = DIV_MAX + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb limit = (CNT_W'(1) << clamp_div(code, DIV_MAX)) - CNT_W'(1);
  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_chan_shift.sv
`timescale 1ns/1ps
module spi_chan_shift #(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        start,
  input  logic [DATA_W-1:0]           tx_word,
  input  logic [$clog2(DATA_W):0]     nbits,
  input  logic                        cpol,
  input  logic                        cpha,
  input  logic                        tick,
  input  logic                        din,
  output logic                        busy,
  output logic                        done,
  output logic [DATA_W-1:0]           rx_word,
  output logic                        sclk,
  output logic                        dout
);
  localparam int LEN_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] txsh, rxsh;
  logic [LEN_W-1:0]  bit_idx;
  logic              half;
  logic              last_bit;

  assign last_bit = (bit_idx == nbits - LEN_W'(1));
  assign done     = busy && tick && half && last_bit;
  assign rx_word  = rxsh;
  assign dout     = txsh[DATA_W-1];
  // first half of a bit slot sits at cpol^cpha, second half at the opposite
  assign sclk     = busy ? (cpol ^ cpha ^ half) : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; half <= 1'b0; bit_idx <= '0; txsh <= '0; rxsh <= '0;
    end else if (clr) begin
      busy <= 1'b0; half <= 1'b0; bit_idx <= '0; txsh <= '0; rxsh <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      half    <= 1'b0;
      bit_idx <= '0;
      txsh    <= tx_word << (LEN_W'(DATA_W) - nbits);
      rxsh    <= '0;
    end else if (busy && tick) begin
      if (!half) begin
        half <= 1'b1;
        rxsh <= {rxsh[DATA_W-2:0], din};
      end else begin
        half <= 1'b0;
        if (last_bit) busy <= 1'b0;
        else begin
          bit_idx <= bit_idx + LEN_W'(1);
          txsh    <= txsh << 1;
        end
      end
    end
  end

  // R3
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bit_idx < nbits));

  // R3
  rx_justify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rx_word >> nbits) == '0));
endmodule

// File: rtl/spi_chan_regs.sv
`timescale 1ns/1ps
module spi_chan_regs
  import spi_chan_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  output logic [DATA_W-1:0] cfg,
  output logic [DATA_W-1:0] txd,
  output logic              start_go,
  output logic              soft_clr
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic              en, txd_full, rx_run, rxs;
  logic [DATA_W-1:0] rxd;
  logic [RC_W-1:0]   rst_cnt;
  xfer_mode_e        mode;
  reg_addr_e         addr;
  logic              wr_cfg, wr_en, wr_txd, wr_sys, rd_rxd, eot;

  assign mode     = xfer_mode_e'(cfg[CFG_MD_LO+1:CFG_MD_LO]);
  assign addr     = reg_addr_e'(reg_addr);
  assign soft_clr = (rst_cnt != '0);
  assign wr_cfg   = reg_wr && !soft_clr && addr == A_CFG;
  assign wr_en    = reg_wr && !soft_clr && addr == A_EN;
  assign wr_txd   = reg_wr && !soft_clr && addr == A_TXD;
  assign wr_sys   = reg_wr && !soft_clr && addr == A_SYSCTL;
  assign rd_rxd   = reg_rd && addr == A_RXD;
  assign eot      = !busy && !txd_full;
  assign start_go = en && !busy && !soft_clr &&
                    ((mode == M_RXONLY) ? rx_run : txd_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; en <= 1'b0; txd <= '0; txd_full <= 1'b0; rx_run <= 1'b0;
      rxd <= '0; rxs <= 1'b0; rst_cnt <= '0;
    end else if (soft_clr) begin
      cfg <= '0; en <= 1'b0; txd <= '0; txd_full <= 1'b0; rx_run <= 1'b0;
      rxd <= '0; rxs <= 1'b0; rst_cnt <= rst_cnt - RC_W'(1);
    end else begin
      if (wr_sys && reg_wdata[0]) rst_cnt <= RC_W'(RST_CYCLES);
      if (wr_cfg && !busy && !start_go) cfg <= reg_wdata;
      if (wr_en) en <= reg_wdata[0];
      if (!en) rx_run <= 1'b0;
      if (start_go && mode != M_RXONLY) txd_full <= 1'b0;
      if (wr_txd) begin
        txd <= reg_wdata;
        if (mode == M_RXONLY) begin
          if (en) rx_run <= 1'b1;
        end else txd_full <= 1'b1;
      end
      if (done && mode != M_TXONLY) begin
        rxs <= 1'b1;
        rxd <= rx_word;
      end else if (rd_rxd) rxs <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CFG:     reg_rdata = cfg;
      A_STAT:    reg_rdata = DATA_W'({eot, !txd_full, rxs});
      A_EN:      reg_rdata = DATA_W'(en);
      A_TXD:     reg_rdata = txd;
      A_RXD:     reg_rdata = rxd;
      A_SYSSTAT: reg_rdata = DATA_W'(!soft_clr);
      default:   reg_rdata = '0;
    endcase
  end

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !soft_clr) |=> $stable(cfg));

  // R12
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (cfg == '0 && !en && !txd_full && !rxs));

  // R5
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode != M_TXONLY && !soft_clr) |=> rxs);

  // R6
  tx_only_norx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TXONLY && !rxs && !soft_clr) |=> !rxs);
endmodule

// File: rtl/spi_chan_master.sv
`timescale 1ns/1ps
module spi_chan_master
  import spi_chan_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4,
  parameter int DIV_MAX    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sclk,
  output logic              cs_out,
  output logic              d0_o,
  output logic              d0_oe,
  input  logic              d0_i,
  output logic              d1_o,
  output logic              d1_oe,
  input  logic              d1_i
);
  localparam int LEN_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] cfg, txd, rx_word;
  logic              start_go, soft_clr, busy, done, tick, din, dout;
  logic [LEN_W-1:0]  nbits;
  logic              cfg_unused;

  assign nbits      = LEN_W'(word_bits(cfg[CFG_WL_LO+4:CFG_WL_LO]));
  assign din        = cfg[CFG_IN_SEL] ? d1_i : d0_i;
  assign d0_o       = dout;
  assign d1_o       = dout;
  assign d0_oe      = !cfg[CFG_NO_D0];
  assign d1_oe      = !cfg[CFG_NO_D1];
  assign cs_out     = cfg[CFG_FORCE] ^ cfg[CFG_EPOL];
  assign cfg_unused = ^{cfg[DATA_W-1:CFG_FORCE+1], cfg[19], cfg[15:14]};

  spi_chan_regs #(.DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .busy, .done, .rx_word, .cfg, .txd, .start_go, .soft_clr
  );

  spi_chan_clkdiv #(.DIV_MAX(DIV_MAX)) u_div (
    .clk, .rst_n, .run(busy), .code(cfg[CFG_DIV_LO+3:CFG_DIV_LO]), .tick
  );

  spi_chan_shift #(.DATA_W(DATA_W)) u_shift (
    .clk, .rst_n, .clr(soft_clr), .start(start_go), .tx_word(txd), .nbits,
    .cpol(cfg[CFG_CPOL]), .cpha(cfg[CFG_CPHA]), .tick, .din,
    .busy, .done, .rx_word, .sclk, .dout
  );
endmodule

// File: tb/tb_spi_chan_master.sv
`timescale 1ns/1ps
module tb_spi_chan_master;
  localparam logic [2:0] CFG = 3'd0, STAT = 3'd1, EN = 3'd2, TXD = 3'd3,
                         RXD = 3'd4, SYSCTL = 3'd5, SYSSTAT = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd7;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, cs_out, d0_o, d0_oe, d0_i, d1_o, d1_oe, d1_i;

  always #2.5 clk = ~clk;

  spi_chan_master dut (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .sclk, .cs_out, .d0_o, .d0_oe, .d0_i, .d1_o, .d1_oe, .d1_i
  );

  int errs = 0, checks = 0;

  // slave model / scoreboard state
  bit b_cpol = 0, b_cpha = 0, b_swap = 0, mon_en = 0;
  int b_w = 8, scnt = 0, edge_cnt = 0;
  logic [31:0] cap = '0, cur_sl = '0, mon_e;
  logic [31:0] exp_q[$];
  logic [31:0] sl_q[$];
  logic miso = 1'b0;
  realtime t_prev = 0, last_per = 0;
  wire mosi = b_swap ? d0_o : d1_o;
  assign d0_i = b_swap ? 1'b0 : miso;
  assign d1_i = b_swap ? miso : 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: capture at the mid-slot edge, pop expected word at word end
  always @(sclk) begin
    if (mon_en) edge_cnt++;
    if (mon_en && sclk === ~(b_cpol ^ b_cpha)) begin
      if (scnt > 0) last_per = $realtime - t_prev;
      t_prev = $realtime;
      cap = {cap[30:0], mosi};
      scnt++;
      if (scnt == b_w) begin
        if (exp_q.size() > 0) begin
          mon_e = exp_q.pop_front();
          chk(cap == mon_e, "R2 serial output word", cap, mon_e);
        end
        scnt = 0;
        cap = '0;
        cur_sl = (sl_q.size() > 0) ? sl_q.pop_front() : '0;
      end
      #1 miso = cur_sl[b_w-1-scnt];
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 3'd7;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #0.5 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; reg_addr = 3'd7;
  endtask

  function automatic logic [31:0] wmask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  function automatic logic [31:0] mkcfg(input bit cpol, input bit cpha, input int code, input int w,
                                        input int mode, input bit swap, input bit epol, input bit force_cs);
    logic [31:0] c;
    c = '0;
    c[0] = cpha; c[1] = cpol; c[5:2] = code[3:0]; c[6] = epol;
    c[11:7] = 5'(w - 1); c[13:12] = mode[1:0];
    c[16] = !swap; c[17] = swap; c[18] = swap; c[20] = force_cs;
    return c;
  endfunction

  task automatic setmode(input bit cpol, input bit cpha, input int code, input int w,
                         input int mode, input bit swap);
    mon_en = 0;
    b_cpol = cpol; b_cpha = cpha; b_w = w; b_swap = swap;
    wr(CFG, mkcfg(cpol, cpha, code, w, mode, swap, 1'b1, 1'b1));
    mon_en = 1;
  endtask

  task automatic prep(input logic [31:0] first);
    scnt = 0; cap = '0; cur_sl = first; miso = first[b_w-1];
  endtask

  task automatic wait_stat(input int b);
    logic [31:0] s;
    for (int i = 0; i < 50000; i++) begin
      rd(STAT, s);
      if (s[b]) return;
    end
    chk(1'b0, "R8 status poll timeout", s, 32'h0);
  endtask

  task automatic run_fd(input bit cpol, input bit cpha, input int code, input int w,
                        input bit swap, input logic [31:0] tx, input logic [31:0] sl);
    logic [31:0] s, r;
    setmode(cpol, cpha, code, w, 0, swap);
    wr(EN, 32'h1);
    prep(sl);
    exp_q.push_back(tx & wmask(w));
    wr(TXD, tx);
    rd(STAT, s);
    chk(s[2] == 1'b0, "R8 end-of-transfer low while shifting", s, 32'h0);
    wait_stat(2);
    rd(STAT, s);
    chk(s == 32'h7, "R5 receive flag set at word end", s, 32'h7);
    rd(RXD, r);
    chk(r == (sl & wmask(w)), "R3 received word right-justified", r, sl & wmask(w));
    rd(STAT, s);
    chk(s == 32'h6, "R5 receive read clears flag", s, 32'h6);
    chk(exp_q.size() == 0, "R2 serial word observed", 32'(exp_q.size()), 32'h0);
    chk(sclk == cpol, "R2 sclk idle level", 32'(sclk), 32'(cpol));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] s, r, c0;
    int e0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(STAT, s);    chk(s == 32'h6, "R1 status after reset", s, 32'h6);
    rd(SYSSTAT, s); chk(s == 32'h1, "R1 reset-done after reset", s, 32'h1);
    rd(CFG, s);     chk(s == 32'h0, "R1 configuration after reset", s, 32'h0);
    chk(cs_out == 1'b0, "R1 chip-select after reset", 32'(cs_out), 32'h0);

    // R2 R3 R4 R5: four clock modes, several lengths
    run_fd(0, 0, 0, 8, 0, 32'hA5, 32'h3C);
    chk(last_per == 10.0, "R4 divider code 0 period ns", 32'(int'(last_per)), 32'd10);
    chk(d0_oe == 1'b0 && d1_oe == 1'b1, "R10 default pin direction", {d0_oe, d1_oe}, 32'h1);
    run_fd(1, 1, 2, 12, 0, 32'hABC, 32'h5A5);
    run_fd(0, 1, 1, 32, 0, 32'hDEADBEEF, 32'h12345678);
    run_fd(1, 0, 0, 4, 0, 32'hFFF9, 32'hFFF6);
    run_fd(0, 0, 3, 8, 0, 32'h81, 32'h7E);
    chk(last_per == 80.0, "R4 divider code 3 period ns", 32'(int'(last_per)), 32'd80);

    // R10 swapped pins
    run_fd(0, 0, 1, 16, 1, 32'hC3A5, 32'h1234);
    chk(d0_oe == 1'b1 && d1_oe == 1'b0, "R10 swapped pin direction", {d0_oe, d1_oe}, 32'h2);

    // R6 transmit only
    setmode(1, 1, 0, 8, 2, 0);
    wr(EN, 32'h1); prep(32'hFF);
    exp_q.push_back(32'h5A);
    wr(TXD, 32'h5A);
    wait_stat(2);
    rd(STAT, s); chk(s == 32'h6, "R6 no receive flag in transmit-only", s, 32'h6);
    chk(exp_q.size() == 0, "R6 transmit-only word sent", 32'(exp_q.size()), 32'h0);

    // R7 receive only, continuous
    setmode(0, 0, 1, 8, 1, 0);
    wr(EN, 32'h1); prep(32'h11);
    sl_q.push_back(32'h22); sl_q.push_back(32'h33); sl_q.push_back(32'h44);
    wr(TXD, 32'h0);
    wait_stat(0); rd(RXD, r); chk(r == 32'h11, "R7 first received word", r, 32'h11);
    wait_stat(0); rd(RXD, r); chk(r == 32'h22, "R7 second received word", r, 32'h22);
    wr(EN, 32'h0);
    wait_stat(2);
    e0 = edge_cnt;
    repeat (200) @(posedge clk);
    chk(edge_cnt == e0, "R7 sclk idle after disable", 32'(edge_cnt - e0), 32'h0);
    mon_en = 0; sl_q.delete();

    // R4 clamp of divider code
    run_fd(0, 0, 15, 4, 0, 32'hA, 32'h5);
    chk(last_per == 40960.0, "R4 divider code 15 clamped period ns", 32'(int'(last_per)), 32'd40960);

    // R9 chip-select control
    mon_en = 0;
    wr(CFG, mkcfg(0, 0, 0, 8, 0, 0, 1'b1, 1'b0));
    chk(cs_out == 1'b1, "R9 inactive low-polarity chip-select", 32'(cs_out), 32'h1);
    wr(CFG, mkcfg(0, 0, 0, 8, 0, 0, 1'b1, 1'b1));
    chk(cs_out == 1'b0, "R9 forced low-polarity chip-select", 32'(cs_out), 32'h0);
    wr(CFG, mkcfg(0, 0, 0, 8, 0, 0, 1'b0, 1'b1));
    chk(cs_out == 1'b1, "R9 forced high-polarity chip-select", 32'(cs_out), 32'h1);
    wr(CFG, mkcfg(0, 0, 0, 8, 0, 0, 1'b0, 1'b0));
    chk(cs_out == 1'b0, "R9 inactive high-polarity chip-select", 32'(cs_out), 32'h0);

    // R11 configuration write while shifting
    setmode(0, 0, 3, 16, 0, 0);
    rd(CFG, c0);
    wr(EN, 32'h1); prep(32'h0);
    exp_q.push_back(32'hBEEF);
    wr(TXD, 32'hBEEF);
    wr(CFG, mkcfg(1, 1, 0, 8, 2, 1, 1'b0, 1'b0));
    rd(CFG, s); chk(s == c0, "R11 configuration held during word", s, c0);
    wait_stat(2);
    chk(exp_q.size() == 0, "R11 word completed unchanged", 32'(exp_q.size()), 32'h0);
    mon_en = 0;

    // R12 soft reset
    wr(CFG, mkcfg(1, 0, 5, 20, 2, 0, 1'b0, 1'b1));
    wr(EN, 32'h1);
    wr(SYSCTL, 32'h1);
    rd(SYSSTAT, s); chk(s == 32'h0, "R12 reset-done low during reset", s, 32'h0);
    repeat (8) @(posedge clk);
    rd(SYSSTAT, s); chk(s == 32'h1, "R12 reset-done high after reset", s, 32'h1);
    rd(CFG, s);     chk(s == 32'h0, "R12 configuration cleared", s, 32'h0);
    rd(EN, s);      chk(s == 32'h0, "R12 enable cleared", s, 32'h0);
    rd(STAT, s);    chk(s == 32'h6, "R12 status default", s, 32'h6);
    chk(cs_out == 1'b0, "R12 chip-select released", 32'(cs_out), 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule